// File: doc/BRIEF.md
# Configuration-Space Target for One Function of a Multi-Function Bus Device

This block is the configuration-space responder for a single function inside a multi-function device on a parallel shared bus. It watches each address phase and accepts a configuration cycle only when it belongs to this function. It then walks a 16-dword predefined header, one dword per data phase, for as long as the initiator keeps the burst open. Each data phase either returns the selected dword or merges write data into it.

Identification fields are constants fixed by parameters. The command word, the status word, the latency timer, one memory base address register and the interrupt line are the only stored state. Status error bits are raised by the rest of the device through a set input and cleared by software writing ones. Every location the header reserves, or that this function leaves out, reads as zero and ignores writes. Writes to those locations still complete normally.

The handshake is deliberately simple. One cycle after an accepted address phase the block raises a combined select/ready acknowledge. Every acknowledged cycle is a data phase. The data phase in which the frame strobe is seen high is the last one.

Top module: `pcicfg_fn_target`

## Requirements
- R1: An address phase (first cycle with `frame_n` low while idle) is accepted only when `idsel` is 1, `ad[1:0]` is 2'b00 and `cbe_n` holds 4'b1010 (configuration read) or 4'b1011 (configuration write). Otherwise no data phase of that transaction is acknowledged, and its write data changes nothing.
- R2: The address phase is accepted only when `ad[10:8]` equals FUNC_NUM, which is 3'd1 by default.
- R3: `ack` is 1 in the cycle after an accepted address phase and stays 1 while `frame_n` is low. The acknowledged cycle in which `frame_n` is high is the last data phase, and `ack` is 0 in the cycle after it.
- R4: `ad[7:2]` of the address phase is the dword index of the first data phase. The index increases by one per data phase and wraps from 63 to 0.
- R5: During a write data phase, active-low `cbe_n[i]` set to 0 enables byte lane i (bits 8i+7:8i). A lane whose enable is 1 keeps its old value.
- R6: Dword 0 reads {DEVICE_ID, VENDOR_ID}, dword 2 reads {CLASS_CODE, REVISION} and dword 11 reads {SUBSYS_ID, SUBSYS_VID}. Writes to them are discarded.
- R7: Bits [15:0] of dword 1 are the command word. Only bits set in CMD_WMASK (default 16'h0146) are writable and reset to 0; all other command bits read 0.
- R8: Bits [31:16] of dword 1 are the status word. A bit in STS_W1C_MASK (default 16'hF900) is set by a 1 on the matching bit of `sts_set`, which wins over a clear in the same cycle. It is cleared by writing 1 to it, and writing 0 leaves it unchanged. The bits of STS_FIXED (default 16'h0200) always read 1.
- R9: Dwords 5 to 10, 12 to 14 and 16 to 63 read zero and ignore writes. This covers the card information pointer (dword 10) and the expansion ROM base (dword 12).
- R10: Dword 3 reads {8'h00, HDR_TYPE, latency timer, 8'h00`}`, so the built-in-test byte and the cache line size read zero. Only the bits of LAT_WMASK (default 8'hF8) in the latency timer are writable.
- R11: Dword 4 is a 32-bit memory base register of 2^BAR_LOG2 bytes (default 4096). Bits [31:BAR_LOG2] are writable and reset to 0, and the lower bits read 0.
- R12: Dword 15 reads {MAX_LAT, MIN_GNT, INT_PIN, interrupt line}, and only the interrupt line byte is writable.
- R13: `rd_data` carries the addressed dword during an acknowledged read data phase and is zero in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_n | input | 1 | Active-low transaction frame; high during the last data phase |
| idsel | input | 1 | Configuration select for this device |
| ad | input | 32 | Address in the address phase, write data in data phases |
| cbe_n | input | 4 | Command in the address phase, active-low byte enables in data phases |
| sts_set | input | 16 | Pulses that set status error bits |
| ack | output | 1 | Combined select/ready acknowledge; 1 in every data phase |
| rd_data | output | 32 | Read data of the current data phase |

## Verification
Random transactions mix accepted cycles with four kinds of rejected ones: `idsel` low, another function number, nonzero `ad[1:0]` and a non-configuration command. Every rejected write carries data that would change state, so a following read tells a true rejection from a silent write. Bursts of one to four phases start at random dwords, some of them near 63, which checks index stepping and wrap-around. Random byte enables and data separate the writable, write-one-to-clear and constant bits of each word. Directed passes read the full header after reset, write all ones with all lanes enabled, and raise and clear status bits to check that set wins over clear.

// File: rtl/pcicfg_pkg.sv
package pcicfg_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_DATA = 2'd1,
      ST_SKIP = 2'd2
   } cfg_state_e;

   localparam int          ADDR_LSB   = 2;
   localparam int          ADDR_MSB   = 7;
   localparam int          IDX_W      = ADDR_MSB - ADDR_LSB + 1;
   localparam int          HDR_DWORDS = 16;
   localparam int          LANES      = 4;

   localparam logic [3:0]  CMD_CFG_RD = 4'b1010;
   localparam logic [3:0]  CMD_CFG_WR = 4'b1011;

   localparam logic [IDX_W-1:0] IDX_ID     = 6'd0;
   localparam logic [IDX_W-1:0] IDX_CMDSTS = 6'd1;
   localparam logic [IDX_W-1:0] IDX_CLASS  = 6'd2;
   localparam logic [IDX_W-1:0] IDX_MISC   = 6'd3;
   localparam logic [IDX_W-1:0] IDX_BAR0   = 6'd4;
   localparam logic [IDX_W-1:0] IDX_SUBSYS = 6'd11;
   localparam logic [IDX_W-1:0] IDX_INTR   = 6'd15;

   function automatic logic [31:0] lane_mask(input logic [LANES-1:0] be_n);
      logic [31:0] m;
      for (int i = 0; i < LANES; i++) begin
         m[8*i +: 8] = {8{~be_n[i]}};
      end
      return m;
   endfunction

   function automatic logic [31:0] merge_bits(input logic [31:0] old_v,
                                              input logic [31:0] new_v,
                                              input logic [31:0] wmask);
      return (old_v & ~wmask) | (new_v & wmask);
   endfunction

endpackage

// File: rtl/pcicfg_cycle_ctl.sv
module pcicfg_cycle_ctl
   import pcicfg_pkg::*;
#(
   parameter logic [2:0] FUNC_NUM = 3'd1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_n,
   input  logic             idsel,
   input  logic [31:0]      ad,
   input  logic [3:0]       cbe_n,
   output logic             ack_o,
   output logic             is_wr_o,
   output logic [IDX_W-1:0] idx_o
);

   cfg_state_e state_q;
   logic       start;
   logic       is_cfg_cmd;
   logic       addr_hit;

   assign start      = (state_q == ST_IDLE) && !frame_n;
   assign is_cfg_cmd = (cbe_n == CMD_CFG_RD) || (cbe_n == CMD_CFG_WR);
   assign addr_hit   = start && idsel && (ad[1:0] == 2'b00)
                       && (ad[10:8] == FUNC_NUM) && is_cfg_cmd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         is_wr_o <= 1'b0;
         idx_o   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (addr_hit) begin
                  state_q <= ST_DATA;
                  idx_o   <= ad[ADDR_MSB:ADDR_LSB];
                  is_wr_o <= (cbe_n == CMD_CFG_WR);
               end else if (!frame_n) begin
                  state_q <= ST_SKIP;
               end
            end
            ST_DATA: begin
               idx_o <= idx_o + 1'b1;
               if (frame_n) state_q <= ST_IDLE;
            end
            ST_SKIP: begin
               if (frame_n) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign ack_o = (state_q == ST_DATA);

   a_r3_ack_after_hit: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_o) |-> $past(addr_hit));
   a_r3_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_o && frame_n) |=> !ack_o);
   a_r3_ack_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_o && !frame_n) |=> ack_o);
   a_r4_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_o && !frame_n) |=> (idx_o == $past(idx_o) + 1'b1));
   a_r1_need_idsel: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !idsel) |=> !ack_o);
   a_r2_other_func: assert property (@(posedge clk) disable iff (!rst_n)
      (start && (ad[10:8] != FUNC_NUM)) |=> !ack_o);

endmodule

// File: rtl/pcicfg_regfile.sv
module pcicfg_regfile
   import pcicfg_pkg::*;
#(
   parameter logic [15:0] CMD_WMASK    = 16'h0146,
   parameter logic [15:0] STS_W1C_MASK = 16'hF900,
   parameter logic [7:0]  LAT_WMASK    = 8'hF8,
   parameter bit          BAR_EN       = 1'b1,
   parameter int          BAR_LOG2     = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] idx,
   input  logic [31:0]      wdata,
   input  logic [3:0]       cbe_n,
   input  logic [15:0]      sts_set,
   output logic [15:0]      cmd_q,
   output logic [15:0]      sts_q,
   output logic [7:0]       lat_q,
   output logic [31:0]      bar_q,
   output logic [7:0]       intl_q
);

   localparam logic [31:0] BAR_WMASK = 32'hFFFF_FFFF << BAR_LOG2;

   logic [31:0] bm;
   logic        hit_cs, hit_misc, hit_bar, hit_intr;
   logic [15:0] sts_clr;
   logic [31:0] cs_new, misc_new, intr_new;

   assign bm       = lane_mask(cbe_n);
   assign hit_cs   = wr_en && (idx == IDX_CMDSTS);
   assign hit_misc = wr_en && (idx == IDX_MISC);
   assign hit_bar  = wr_en && (idx == IDX_BAR0);
   assign hit_intr = wr_en && (idx == IDX_INTR);

   assign cs_new   = merge_bits({16'h0, cmd_q}, wdata, {16'h0, CMD_WMASK} & bm);
   assign misc_new = merge_bits({16'h0, lat_q, 8'h0}, wdata,
                                {16'h0, LAT_WMASK, 8'h0} & bm);
   assign intr_new = merge_bits({24'h0, intl_q}, wdata, 32'h0000_00FF & bm);
   assign sts_clr  = hit_cs ? (wdata[31:16] & bm[31:16] & STS_W1C_MASK) : 16'h0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q  <= '0;
         sts_q  <= '0;
         lat_q  <= '0;
         intl_q <= '0;
      end else begin
         if (hit_cs)   cmd_q  <= cs_new[15:0];
         if (hit_misc) lat_q  <= misc_new[15:8];
         if (hit_intr) intl_q <= intr_new[7:0];
         sts_q <= (sts_q & ~sts_clr) | (sts_set & STS_W1C_MASK);
      end
   end

   generate
      if (BAR_EN) begin : g_bar
         logic [31:0] bar_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       bar_r <= '0;
            else if (hit_bar) bar_r <= merge_bits(bar_r, wdata, BAR_WMASK & bm);
         end
         assign bar_q = bar_r;

         a_r11_bar_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !hit_bar |=> $stable(bar_q));
      end else begin : g_nobar
         assign bar_q = '0;
      end
   endgenerate

   a_r7_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_cs |=> $stable(cmd_q));
   a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (|(sts_set & STS_W1C_MASK)) |=>
      ((sts_q & $past(sts_set & STS_W1C_MASK)) == $past(sts_set & STS_W1C_MASK)));
   a_r8_sts_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit_cs && (sts_set == 16'h0)) |=> $stable(sts_q));
   a_r10_lat_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_misc |=> $stable(lat_q));

endmodule

// File: rtl/pcicfg_rd_mux.sv
module pcicfg_rd_mux
   import pcicfg_pkg::*;
#(
   parameter logic [15:0] VENDOR_ID  = 16'h1A2B,
   parameter logic [15:0] DEVICE_ID  = 16'h0C3D,
   parameter logic [7:0]  REVISION   = 8'h11,
   parameter logic [23:0] CLASS_CODE = 24'h048000,
   parameter logic [15:0] SUBSYS_VID = 16'h1A2B,
   parameter logic [15:0] SUBSYS_ID  = 16'h7E01,
   parameter logic [7:0]  HDR_TYPE   = 8'h80,
   parameter logic [15:0] STS_FIXED  = 16'h0200,
   parameter logic [7:0]  INT_PIN    = 8'h01,
   parameter logic [7:0]  MIN_GNT    = 8'h10,
   parameter logic [7:0]  MAX_LAT    = 8'h28
) (
   input  logic             rd_en,
   input  logic [IDX_W-1:0] idx,
   input  logic [15:0]      cmd_q,
   input  logic [15:0]      sts_q,
   input  logic [7:0]       lat_q,
   input  logic [31:0]      bar_q,
   input  logic [7:0]       intl_q,
   output logic [31:0]      rd_data
);

   logic [31:0] sel;

   always_comb begin
      case (idx)
         IDX_ID:     sel = {DEVICE_ID, VENDOR_ID};
         IDX_CMDSTS: sel = {sts_q | STS_FIXED, cmd_q};
         IDX_CLASS:  sel = {CLASS_CODE, REVISION};
         IDX_MISC:   sel = {8'h00, HDR_TYPE, lat_q, 8'h00};
         IDX_BAR0:   sel = bar_q;
         IDX_SUBSYS: sel = {SUBSYS_ID, SUBSYS_VID};
         IDX_INTR:   sel = {MAX_LAT, MIN_GNT, INT_PIN, intl_q};
         default:    sel = 32'h0;
      endcase
   end

   assign rd_data = rd_en ? sel : 32'h0;

endmodule

// File: rtl/pcicfg_fn_target.sv
module pcicfg_fn_target
   import pcicfg_pkg::*;
#(
   parameter logic [2:0]  FUNC_NUM     = 3'd1,
   parameter logic [15:0] VENDOR_ID    = 16'h1A2B,
   parameter logic [15:0] DEVICE_ID    = 16'h0C3D,
   parameter logic [7:0]  REVISION     = 8'h11,
   parameter logic [23:0] CLASS_CODE   = 24'h048000,
   parameter logic [15:0] SUBSYS_VID   = 16'h1A2B,
   parameter logic [15:0] SUBSYS_ID    = 16'h7E01,
   parameter logic [7:0]  HDR_TYPE     = 8'h80,
   parameter logic [15:0] CMD_WMASK    = 16'h0146,
   parameter logic [15:0] STS_W1C_MASK = 16'hF900,
   parameter logic [15:0] STS_FIXED    = 16'h0200,
   parameter logic [7:0]  LAT_WMASK    = 8'hF8,
   parameter bit          BAR_EN       = 1'b1,
   parameter int          BAR_LOG2     = 12,
   parameter logic [7:0]  INT_PIN      = 8'h01,
   parameter logic [7:0]  MIN_GNT      = 8'h10,
   parameter logic [7:0]  MAX_LAT      = 8'h28
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        frame_n,
   input  logic        idsel,
   input  logic [31:0] ad,
   input  logic [3:0]  cbe_n,
   input  logic [15:0] sts_set,
   output logic        ack,
   output logic [31:0] rd_data
);

   generate
      if (BAR_LOG2 < 4 || BAR_LOG2 > 31) begin : g_bad_bar
         $error("BAR_LOG2 must lie in 4..31");
      end
      if ((STS_FIXED & STS_W1C_MASK) != 16'h0) begin : g_bad_sts
         $error("STS_FIXED and STS_W1C_MASK overlap");
      end
   endgenerate

   logic             is_wr;
   logic [IDX_W-1:0] idx;
   logic [15:0]      cmd_q, sts_q;
   logic [7:0]       lat_q, intl_q;
   logic [31:0]      bar_q;

   pcicfg_cycle_ctl #(.FUNC_NUM(FUNC_NUM)) u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .frame_n (frame_n),
      .idsel   (idsel),
      .ad      (ad),
      .cbe_n   (cbe_n),
      .ack_o   (ack),
      .is_wr_o (is_wr),
      .idx_o   (idx)
   );

   pcicfg_regfile #(
      .CMD_WMASK    (CMD_WMASK),
      .STS_W1C_MASK (STS_W1C_MASK),
      .LAT_WMASK    (LAT_WMASK),
      .BAR_EN       (BAR_EN),
      .BAR_LOG2     (BAR_LOG2)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (ack && is_wr),
      .idx     (idx),
      .wdata   (ad),
      .cbe_n   (cbe_n),
      .sts_set (sts_set),
      .cmd_q   (cmd_q),
      .sts_q   (sts_q),
      .lat_q   (lat_q),
      .bar_q   (bar_q),
      .intl_q  (intl_q)
   );

   pcicfg_rd_mux #(
      .VENDOR_ID  (VENDOR_ID),
      .DEVICE_ID  (DEVICE_ID),
      .REVISION   (REVISION),
      .CLASS_CODE (CLASS_CODE),
      .SUBSYS_VID (SUBSYS_VID),
      .SUBSYS_ID  (SUBSYS_ID),
      .HDR_TYPE   (HDR_TYPE),
      .STS_FIXED  (STS_FIXED),
      .INT_PIN    (INT_PIN),
      .MIN_GNT    (MIN_GNT),
      .MAX_LAT    (MAX_LAT)
   ) u_mux (
      .rd_en   (ack && !is_wr),
      .idx     (idx),
      .cmd_q   (cmd_q),
      .sts_q   (sts_q),
      .lat_q   (lat_q),
      .bar_q   (bar_q),
      .intl_q  (intl_q),
      .rd_data (rd_data)
   );

   a_r13_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!ack || is_wr) |-> (rd_data == 32'h0));
   a_r9_beyond_header: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && (idx >= IDX_W'(HDR_DWORDS))) |-> (rd_data == 32'h0));

endmodule

// File: tb/pcicfg_fn_target_tb_top.sv
module pcicfg_fn_target_tb_top;

   localparam logic [15:0] E_VEN  = 16'h1A2B;
   localparam logic [15:0] E_DEV  = 16'h0C3D;
   localparam logic [7:0]  E_REV  = 8'h11;
   localparam logic [23:0] E_CLS  = 24'h048000;
   localparam logic [15:0] E_SVID = 16'h1A2B;
   localparam logic [15:0] E_SID  = 16'h7E01;
   localparam logic [7:0]  E_HDR  = 8'h80;
   localparam logic [15:0] E_CMDM = 16'h0146;
   localparam logic [15:0] E_W1C  = 16'hF900;
   localparam logic [15:0] E_FIX  = 16'h0200;
   localparam logic [7:0]  E_LATM = 8'hF8;
   localparam logic [31:0] E_BARM = 32'hFFFF_F000;
   localparam logic [7:0]  E_PIN  = 8'h01;
   localparam logic [7:0]  E_MING = 8'h10;
   localparam logic [7:0]  E_MAXL = 8'h28;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_n = 1'b1;
   logic        idsel = 1'b0;
   logic [31:0] ad = 32'h0;
   logic [3:0]  cbe_n = 4'hF;
   logic [15:0] sts_set = 16'h0;
   logic        ack;
   logic [31:0] rd_data;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   logic [15:0] m_cmd = 0, m_sts = 0;
   logic [7:0]  m_lat = 0, m_intl = 0;
   logic [31:0] m_bar = 0;

   logic [31:0] wd_a [16];
   logic [3:0]  be_a [16];

   always #5 clk = ~clk;

   pcicfg_fn_target dut_i (
      .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .idsel(idsel), .ad(ad),
      .cbe_n(cbe_n), .sts_set(sts_set), .ack(ack), .rd_data(rd_data)
   );

   function automatic logic [31:0] bmask(input logic [3:0] be_n);
      logic [31:0] m;
      for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{~be_n[i]}};
      return m;
   endfunction

   function automatic logic [31:0] exp_read(input int i);
      case (i)
         0:  return {E_DEV, E_VEN};
         1:  return {m_sts | E_FIX, m_cmd};
         2:  return {E_CLS, E_REV};
         3:  return {8'h00, E_HDR, m_lat, 8'h00};
         4:  return m_bar;
         11: return {E_SID, E_SVID};
         15: return {E_MAXL, E_MING, E_PIN, m_intl};
         default: return 32'h0;
      endcase
   endfunction

   function automatic string req_of(input int i);
      case (i)
         0, 2, 11: return "R6";
         1:        return "R7 R8";
         3:        return "R10";
         4:        return "R11";
         15:       return "R12";
         default:  return "R9";
      endcase
   endfunction

   task automatic model_write(input int i, input logic [31:0] w, input logic [3:0] be);
      logic [31:0] m;
      m = bmask(be);
      case (i)
         1: begin
            m_cmd = (m_cmd & ~(E_CMDM & m[15:0])) | (w[15:0] & E_CMDM & m[15:0]);
            m_sts = m_sts & ~(w[31:16] & E_W1C & m[31:16]);
         end
         3: m_lat = (m_lat & ~(E_LATM & m[15:8])) | (w[15:8] & E_LATM & m[15:8]);
         4: m_bar = (m_bar & ~(E_BARM & m)) | (w & E_BARM & m);
         15: m_intl = (m_intl & ~m[7:0]) | (w[7:0] & m[7:0]);
         default: ;
      endcase
   endtask

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", req, got, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   // One transaction: address phase then len data phases from wd_a/be_a.
   task automatic txn(input logic idsel_v, input logic [31:0] addr,
                      input logic [3:0] cmd, input int len);
      bit hit;
      bit wr;
      int base;
      hit  = idsel_v && (addr[1:0] == 2'b00) && (addr[10:8] == 3'd1)
             && (cmd == 4'b1010 || cmd == 4'b1011);
      wr   = (cmd == 4'b1011);
      base = int'(addr[7:2]);
      @(negedge clk);
      frame_n = 1'b0; idsel = idsel_v; ad = addr; cbe_n = cmd;
      for (int k = 0; k < len; k++) begin
         int i;
         i = (base + k) % 64;
         @(negedge clk);
         idsel = 1'b0; ad = wd_a[k]; cbe_n = be_a[k]; frame_n = (k == len - 1);
         #1;
         check(hit ? "R3 data phase ack" : "R1 R2 ignored cycle", {31'h0, ack}, {31'h0, hit});
         if (hit && !wr) check(req_of(i), rd_data, exp_read(i));
         else            check("R13 idle read data", rd_data, 32'h0);
         if (hit && wr) model_write(i, wd_a[k], be_a[k]);
      end
      @(negedge clk);
      frame_n = 1'b1; ad = 32'h0; cbe_n = 4'hF;
      #1;
      check("R3 ack after last phase", {31'h0, ack}, 32'h0);
   endtask

   task automatic read_all();
      for (int k = 0; k < 16; k++) begin
         wd_a[k] = 32'h0; be_a[k] = 4'h0;
      end
      txn(1'b1, {21'h0, 3'd1, 6'd0, 2'b00}, 4'b1010, 16);
   endtask

   task automatic pulse_sts(input logic [15:0] v);
      @(negedge clk);
      sts_set = v;
      @(negedge clk);
      sts_set = 16'h0;
      m_sts = m_sts | (v & E_W1C);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240917));
      repeat (3) @(negedge clk);
      #1;
      check("R3 ack low in reset", {31'h0, ack}, 32'h0);
      check("R13 rd_data low in reset", rd_data, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      // Reset contents of the whole header (R6..R12).
      read_all();

      // All ones into every header dword with all lanes on (R5 R6 R9 R10 R11 R12).
      for (int k = 0; k < 16; k++) begin
         wd_a[k] = 32'hFFFF_FFFF; be_a[k] = 4'h0;
      end
      txn(1'b1, {21'h0, 3'd1, 6'd0, 2'b00}, 4'b1011, 16);
      read_all();

      // R8: set all status bits, then clear some; set wins same-cycle handled by assertion.
      pulse_sts(16'hFFFF);
      read_all();
      wd_a[0] = 32'h8800_0000; be_a[0] = 4'b0111;   // lane 3 only
      txn(1'b1, {21'h0, 3'd1, 6'd1, 2'b00}, 4'b1011, 1);
      wd_a[0] = 32'h0;          be_a[0] = 4'h0;
      txn(1'b1, {21'h0, 3'd1, 6'd1, 2'b00}, 4'b1010, 1);

      // R4: burst wrapping from dword 62 to 1.
      for (int k = 0; k < 4; k++) begin
         wd_a[k] = 32'h0; be_a[k] = 4'h0;
      end
      txn(1'b1, {21'h0, 3'd1, 6'd62, 2'b00}, 4'b1010, 4);

      // R1 R2: directed ignored writes that would clear the command word.
      wd_a[0] = 32'h0; be_a[0] = 4'h0;
      txn(1'b0, {21'h0, 3'd1, 6'd1, 2'b00}, 4'b1011, 1);
      txn(1'b1, {21'h0, 3'd2, 6'd1, 2'b00}, 4'b1011, 1);
      txn(1'b1, {21'h0, 3'd1, 6'd1, 2'b01}, 4'b1011, 1);
      txn(1'b1, {21'h0, 3'd1, 6'd1, 2'b00}, 4'b0111, 1);
      txn(1'b1, {21'h0, 3'd1, 6'd1, 2'b00}, 4'b1010, 1);

      // Constrained random traffic.
      for (int t = 0; t < 400; t++) begin
         int          mode, len, f, ix;
         logic [1:0]  lo;
         logic        iv;
         logic [3:0]  cmd;
         mode = int'($urandom % 12);
         len  = int'($urandom % 4) + 1;
         ix   = ($urandom % 4 == 0) ? int'($urandom % 64) : int'($urandom % 16);
         f = 1; lo = 2'b00; iv = 1'b1;
         cmd = ($urandom % 2 == 0) ? 4'b1010 : 4'b1011;
         case (mode)
            0: iv = 1'b0;
            1: begin f = int'($urandom % 7); if (f >= 1) f = f + 1; end
            2: lo = 2'(($urandom % 3) + 1);
            3: cmd = 4'b0110;
            default: ;
         endcase
         for (int k = 0; k < len; k++) begin
            wd_a[k] = $urandom;
            be_a[k] = 4'($urandom);
         end
         if ($urandom % 16 == 0) pulse_sts(16'($urandom));
         txn(iv, {21'h0, 3'(f), 6'(ix), lo}, cmd, len);
      end

      read_all();
      finish_run();
   end

endmodule